// File: doc/BRIEF.md
# Permission-Checked Set-Associative Tag Directory

This block holds the tags and per-line state of a set-associative cache. It has no data array. Each way keeps an occupancy flag, the line tag, a two-bit access permission and a lock-owner context. The cache controller sends one command per cycle on a command port. One cycle later the block returns a registered response: a boolean result, an error flag, a way index and, for a victim probe, the victim line address.

A hit needs two things: a tag match on an occupied way whose permission is not NotPresent, and a permission that allows the request type. Each set keeps true-LRU ages. They drive victim selection for eviction. Every address given to the block is line-aligned.

Top module: `tag_directory`

## Requirements
- R1: The set index is `cmd_addr_i[OFF_W +: SET_W]`, with SET_W = log2(SETS). The tag is the bits above it. A line placed in one set is not found by the same tag in another set. A successful probe returns `{tag, set, zero offset}`.
- R2: A way matches only when it is occupied, its tag equals the request and its permission is not NotPresent. Permission codes are 00 NotPresent, 01 Invalid, 10 ReadOnly, 11 ReadWrite. The presence test (op 1) returns the match.
- R3: The access check (op 0) succeeds in two cases: the line is ReadWrite, for any request type, or the line is ReadOnly and the request is load (00) or fetch (01). A store (10) to ReadOnly fails. Invalid fails for every request, and so does a miss.
- R4: Any tag match on an access check makes that way most recently used, even when the permission check fails.
- R5: The availability test (op 2) is true when the set already holds the address, or when some way is empty or NotPresent.
- R6: Allocate (op 3) fills the lowest-numbered empty or NotPresent way and reports that way. The new line has permission Invalid, no lock owner and is most recently used.
- R7: Deallocate (op 4) empties the matching way and clears its lock, so the line no longer matches.
- R8: The victim probe (op 5) on a full set returns the least recently used way and its line address.
- R9: Lock set (op 7) stores `cmd_ctx_i` and lock clear (op 8) stores the all-ones unlocked value. Lock test (op 9) is true only when the stored owner equals `cmd_ctx_i`.
- R10: A permission change (op 6) writes `cmd_perm_i` and clears the line's lock owner.
- R11: The following set `rsp_err_o`, never with `rsp_ok_o`, and leave the state unchanged:
  - allocate on a present tag or a full set;
  - deallocate, permission change or any lock command that misses;
  - a probe on a set with a free way;
  - an undefined op code.
- R12: After reset every way is empty, and the response outputs are low while no response is valid.
- R13: Every command gives exactly one response, valid in the cycle after it is accepted. A command sees the state left by the command before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 4 | Operation code |
| cmd_addr_i | input | ADDR_W | Line-aligned address |
| cmd_req_i | input | 2 | Request type for access check |
| cmd_perm_i | input | 2 | New permission for permission change |
| cmd_ctx_i | input | CTX_W | Context for lock commands |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ok_o | output | 1 | Boolean result of the command |
| rsp_err_o | output | 1 | Command was illegal; state untouched |
| rsp_way_o | output | WAY_W | Way hit, filled or chosen as victim |
| rsp_addr_o | output | ADDR_W | Victim line address for a probe |

## Verification
The hardest situation to reach is the LRU order inside a full set, because the ages can only be seen through a probe, and a probe is legal only once every way is taken. The stimulus fills one set with four allocations and probes it. It then makes a permission-failing store to the victim line and probes again, which shows that a denied hit still refreshes recency. Finally it frees a middle way and refills it, which checks both the lowest-free-way choice and the new victim.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  typedef enum logic [3:0] {
    OP_ACCESS   = 4'd0,
    OP_PRESENT  = 4'd1,
    OP_AVAIL    = 4'd2,
    OP_ALLOC    = 4'd3,
    OP_DEALLOC  = 4'd4,
    OP_PROBE    = 4'd5,
    OP_SETPERM  = 4'd6,
    OP_LOCK_SET = 4'd7,
    OP_LOCK_CLR = 4'd8,
    OP_LOCK_TST = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    PERM_NP  = 2'd0,
    PERM_INV = 2'd1,
    PERM_RO  = 2'd2,
    PERM_RW  = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    REQ_LD = 2'd0,
    REQ_IF = 2'd1,
    REQ_ST = 2'd2
  } req_e;
endpackage

// File: rtl/tagdir_set_match.sv
module tagdir_set_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 22,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  tag_i,
  input  logic [WAYS-1:0][1:0]        perm_i,
  input  logic [TAG_W-1:0]            req_tag_i,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            hit_way_o,
  output logic                        free_any_o,
  output logic [WAY_W-1:0]            free_way_o
);
  import tagdir_pkg::*;

  logic [WAYS-1:0] hit_vec, free_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign free_vec[w] = !valid_i[w] || (perm_i[w] == PERM_NP);
    assign hit_vec[w]  = !free_vec[w] && (tag_i[w] == req_tag_i);
  end

  assign hit_o      = |hit_vec;
  assign free_any_o = |free_vec;

  // descending scan so the lowest index wins
  always_comb begin
    hit_way_o  = '0;
    free_way_o = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (hit_vec[w])  hit_way_o  = WAY_W'(w);
      if (free_vec[w]) free_way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/tagdir_lru.sv
module tagdir_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [SET_W-1:0] query_set_i,
  output logic [WAY_W-1:0] victim_way_o
);
  // age 0 = most recent, WAYS-1 = least recent; ages form a permutation
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;
  logic [WAY_W-1:0] touched_age;

  assign touched_age = age_q[touch_set_i][touch_way_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[touch_set_i][w] <= '0;
        else if (age_q[touch_set_i][w] < touched_age)
          age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[query_set_i][w] == WAY_W'(WAYS-1)) victim_way_o = WAY_W'(w);
  end
endmodule

// File: rtl/tag_directory.sv
module tag_directory #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int CTX_W  = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - OFF_W - SET_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [3:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [1:0]        cmd_req_i,
  input  logic [1:0]        cmd_perm_i,
  input  logic [CTX_W-1:0]  cmd_ctx_i,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic              rsp_err_o,
  output logic [WAY_W-1:0]  rsp_way_o,
  output logic [ADDR_W-1:0] rsp_addr_o
);
  import tagdir_pkg::*;

  localparam logic [CTX_W-1:0] CTX_NONE = '1;

  logic [SETS-1:0][WAYS-1:0]             valid_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0][1:0]        perm_q;
  logic [SETS-1:0][WAYS-1:0][CTX_W-1:0]  lock_q;

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag;
  op_e              op;
  logic             hit, free_any;
  logic [WAY_W-1:0] hit_way, free_way, victim_way, touch_way;
  logic [1:0]       hit_perm;
  logic             n_ok, n_err, touch;
  logic [WAY_W-1:0] n_way;
  logic [ADDR_W-1:0] n_addr;
  logic             unused_offset;

  assign set_idx       = cmd_addr_i[OFF_W +: SET_W];
  assign req_tag       = cmd_addr_i[ADDR_W-1 -: TAG_W];
  assign op            = op_e'(cmd_op_i);
  assign unused_offset = ^cmd_addr_i[OFF_W-1:0];

  tagdir_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .valid_i    (valid_q[set_idx]),
    .tag_i      (tag_q[set_idx]),
    .perm_i     (perm_q[set_idx]),
    .req_tag_i  (req_tag),
    .hit_o      (hit),
    .hit_way_o  (hit_way),
    .free_any_o (free_any),
    .free_way_o (free_way)
  );

  assign touch_way = (op == OP_ALLOC) ? free_way : hit_way;

  tagdir_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .touch_i      (cmd_valid_i && touch),
    .touch_set_i  (set_idx),
    .touch_way_i  (touch_way),
    .query_set_i  (set_idx),
    .victim_way_o (victim_way)
  );

  assign hit_perm = perm_q[set_idx][hit_way];

  always_comb begin
    n_ok   = 1'b0;
    n_err  = 1'b0;
    touch  = 1'b0;
    n_way  = hit_way;
    n_addr = '0;
    unique case (op)
      OP_ACCESS: begin
        touch = hit;
        n_ok  = hit && ((hit_perm == PERM_RW) ||
                ((hit_perm == PERM_RO) && (cmd_req_i == REQ_LD || cmd_req_i == REQ_IF)));
      end
      OP_PRESENT: n_ok = hit;
      OP_AVAIL:   n_ok = hit || free_any;
      OP_ALLOC: begin
        n_way = free_way;
        if (hit || !free_any) n_err = 1'b1;
        else begin
          n_ok  = 1'b1;
          touch = 1'b1;
        end
      end
      OP_PROBE: begin
        n_way = victim_way;
        if (free_any) n_err = 1'b1;
        else begin
          n_ok   = 1'b1;
          n_addr = {tag_q[set_idx][victim_way], set_idx, {OFF_W{1'b0}}};
        end
      end
      OP_DEALLOC, OP_SETPERM, OP_LOCK_SET, OP_LOCK_CLR: begin
        n_err = !hit;
        n_ok  = hit;
      end
      OP_LOCK_TST: begin
        n_err = !hit;
        n_ok  = hit && (lock_q[set_idx][hit_way] == cmd_ctx_i);
      end
      default: n_err = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      perm_q  <= '0;
      lock_q  <= '1;
    end else if (cmd_valid_i && !n_err) begin
      unique case (op)
        OP_ALLOC: begin
          valid_q[set_idx][free_way] <= 1'b1;
          tag_q[set_idx][free_way]   <= req_tag;
          perm_q[set_idx][free_way]  <= PERM_INV;
          lock_q[set_idx][free_way]  <= CTX_NONE;
        end
        OP_DEALLOC: begin
          valid_q[set_idx][hit_way] <= 1'b0;
          perm_q[set_idx][hit_way]  <= PERM_NP;
          lock_q[set_idx][hit_way]  <= CTX_NONE;
        end
        OP_SETPERM: begin
          perm_q[set_idx][hit_way] <= cmd_perm_i;
          lock_q[set_idx][hit_way] <= CTX_NONE;
        end
        OP_LOCK_SET: lock_q[set_idx][hit_way] <= cmd_ctx_i;
        OP_LOCK_CLR: lock_q[set_idx][hit_way] <= CTX_NONE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_ok_o    <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_way_o   <= '0;
      rsp_addr_o  <= '0;
    end else begin
      rsp_valid_o <= cmd_valid_i;
      rsp_ok_o    <= cmd_valid_i && n_ok;
      rsp_err_o   <= cmd_valid_i && n_err;
      rsp_way_o   <= n_way;
      rsp_addr_o  <= n_addr;
    end
  end
endmodule

// File: rtl/tag_directory_checker.sv
module tag_directory_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int SET_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [3:0]        cmd_op_i,
  input logic [ADDR_W-1:0] cmd_addr_i,
  input logic              rsp_valid_o,
  input logic              rsp_ok_o,
  input logic              rsp_err_o,
  input logic [ADDR_W-1:0] rsp_addr_o
);
  a_r13_rsp_follows_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> rsp_valid_o);

  a_r13_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !rsp_valid_o);

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_ok_o && !rsp_err_o));

  a_r11_err_excludes_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> !rsp_ok_o);

  a_r11_alloc_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 4'd3) |=> (rsp_ok_o != rsp_err_o));

  a_r1_probe_addr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 4'd5) |=>
      (rsp_err_o || ((rsp_addr_o[OFF_W +: SET_W] == $past(cmd_addr_i[OFF_W +: SET_W])) &&
                     (rsp_addr_o[OFF_W-1:0] == '0))));

  a_r2_present_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 4'd1) |=> !rsp_err_o);
endmodule

bind tag_directory tag_directory_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .cmd_addr_i  (cmd_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ok_o    (rsp_ok_o),
  .rsp_err_o   (rsp_err_o),
  .rsp_addr_o  (rsp_addr_o)
);

// File: tb/tag_directory_tb.sv
module tag_directory_tb;
  localparam int ADDR_W = 32;
  localparam int OFF_W  = 6;
  localparam int SET_W  = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cmd_valid_i = 1'b0;
  logic [3:0]        cmd_op_i = '0;
  logic [ADDR_W-1:0] cmd_addr_i = '0;
  logic [1:0]        cmd_req_i = '0;
  logic [1:0]        cmd_perm_i = '0;
  logic [3:0]        cmd_ctx_i = '0;
  logic              rsp_valid_o, rsp_ok_o, rsp_err_o;
  logic [1:0]        rsp_way_o;
  logic [ADDR_W-1:0] rsp_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tag_directory u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_addr_i(cmd_addr_i), .cmd_req_i(cmd_req_i), .cmd_perm_i(cmd_perm_i),
    .cmd_ctx_i(cmd_ctx_i), .rsp_valid_o(rsp_valid_o), .rsp_ok_o(rsp_ok_o),
    .rsp_err_o(rsp_err_o), .rsp_way_o(rsp_way_o), .rsp_addr_o(rsp_addr_o)
  );

  typedef struct {
    logic              ok;
    logic              err;
    int                way;   // -1: not checked
    logic              chk_addr;
    logic [ADDR_W-1:0] addr;
    int                rq;
  } exp_t;

  exp_t sb_q[$];

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int set);
    return {22'(tag), 4'(set), 6'b0};
  endfunction

  task automatic issue(input logic [3:0] op, input logic [ADDR_W-1:0] a,
                       input logic [1:0] rq_t, input logic [1:0] pm, input logic [3:0] cx,
                       input logic eok, input logic eerr, input int ew,
                       input logic ca, input logic [ADDR_W-1:0] ea, input int rn);
    exp_t e;
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_addr_i = a;
    cmd_req_i = rq_t; cmd_perm_i = pm; cmd_ctx_i = cx;
    e.ok = eok; e.err = eerr; e.way = ew; e.chk_addr = ca; e.addr = ea; e.rq = rn;
    sb_q.push_back(e);
  endtask

  task automatic simple(input logic [3:0] op, input logic [ADDR_W-1:0] a,
                        input logic eok, input logic eerr, input int rn);
    issue(op, a, 2'd0, 2'd0, 4'd0, eok, eerr, -1, 1'b0, '0, rn);
  endtask

  // monitor: one scoreboard entry per response
  always @(negedge clk) begin
    if (rst_ni && rsp_valid_o && !done) begin
      exp_t e;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R13 unexpected response ok=%0b err=%0b, expected none", rsp_ok_o, rsp_err_o);
      end else begin
        e = sb_q.pop_front();
        if (rsp_ok_o !== e.ok || rsp_err_o !== e.err ||
            (e.way >= 0 && int'(rsp_way_o) != e.way) ||
            (e.chk_addr && rsp_addr_o !== e.addr)) begin
          errors++;
          $display("FAIL R%0d ok=%0b err=%0b way=%0d addr=%h, expected ok=%0b err=%0b way=%0d addr=%h",
                   e.rq, rsp_ok_o, rsp_err_o, rsp_way_o, rsp_addr_o,
                   e.ok, e.err, e.way, e.addr);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++; // R12 reset state
    if (rsp_valid_o !== 1'b0 || rsp_ok_o !== 1'b0 || rsp_err_o !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset outputs valid=%0b ok=%0b err=%0b, expected 0 0 0",
               rsp_valid_o, rsp_ok_o, rsp_err_o);
    end
    rst_ni = 1'b1;

    simple(4'd1, mk(5,3), 0, 0, 12);                          // R12 empty after reset
    simple(4'd2, mk(5,3), 1, 0, 5);                           // R5 free way
    issue(4'd3, mk(5,3), 0, 0, 0, 1, 0, 0, 0, '0, 6);         // R6 lowest way 0
    simple(4'd3, mk(5,3), 0, 1, 11);                          // R11 already present
    simple(4'd1, mk(5,3), 1, 0, 2);                           // R2 Invalid still matches
    issue(4'd0, mk(5,3), 2'd0, 0, 0, 0, 0, -1, 0, '0, 3);     // R3 Invalid load fails
    issue(4'd6, mk(5,3), 0, 2'd2, 0, 1, 0, -1, 0, '0, 10);    // R10 to ReadOnly
    issue(4'd0, mk(5,3), 2'd0, 0, 0, 1, 0, 0, 0, '0, 3);      // R3 RO load
    issue(4'd0, mk(5,3), 2'd1, 0, 0, 1, 0, 0, 0, '0, 3);      // R3 RO fetch
    issue(4'd0, mk(5,3), 2'd2, 0, 0, 0, 0, -1, 0, '0, 3);     // R3 RO store fails
    issue(4'd6, mk(5,3), 0, 2'd3, 0, 1, 0, -1, 0, '0, 10);    // R10 to ReadWrite
    issue(4'd0, mk(5,3), 2'd2, 0, 0, 1, 0, 0, 0, '0, 3);      // R3 RW store
    issue(4'd7, mk(5,3), 0, 0, 4'd7, 1, 0, -1, 0, '0, 9);     // R9 lock to 7
    issue(4'd9, mk(5,3), 0, 0, 4'd7, 1, 0, -1, 0, '0, 9);     // R9 owner matches
    issue(4'd9, mk(5,3), 0, 0, 4'd2, 0, 0, -1, 0, '0, 9);     // R9 other context
    issue(4'd8, mk(5,3), 0, 0, 4'd0, 1, 0, -1, 0, '0, 9);     // R9 clear
    issue(4'd9, mk(5,3), 0, 0, 4'd7, 0, 0, -1, 0, '0, 9);     // R9 cleared
    issue(4'd7, mk(5,3), 0, 0, 4'd7, 1, 0, -1, 0, '0, 9);
    issue(4'd6, mk(5,3), 0, 2'd3, 0, 1, 0, -1, 0, '0, 10);    // R10 perm write
    issue(4'd9, mk(5,3), 0, 0, 4'd7, 0, 0, -1, 0, '0, 10);    // R10 lock gone
    issue(4'd6, mk(5,3), 0, 2'd0, 0, 1, 0, -1, 0, '0, 2);     // R2 to NotPresent
    simple(4'd1, mk(5,3), 0, 0, 2);                           // R2 NP not matched
    simple(4'd4, mk(5,3), 0, 1, 11);                          // R11 dealloc miss
    issue(4'd3, mk(6,3), 0, 0, 0, 1, 0, 0, 0, '0, 6);         // R6 reuse NP way 0
    issue(4'd3, mk(7,3), 0, 0, 0, 1, 0, 1, 0, '0, 6);         // R6 way 1
    issue(4'd3, mk(8,3), 0, 0, 0, 1, 0, 2, 0, '0, 6);         // R6 way 2
    issue(4'd3, mk(10,3), 0, 0, 0, 1, 0, 3, 0, '0, 6);        // R6 way 3
    simple(4'd2, mk(9,3), 0, 0, 5);                           // R5 full, absent
    simple(4'd2, mk(7,3), 1, 0, 5);                           // R5 full, present
    simple(4'd3, mk(9,3), 0, 1, 11);                          // R11 alloc full
    issue(4'd5, mk(9,3), 0, 0, 0, 1, 0, 0, 1, mk(6,3), 8);    // R8 LRU is way 0
    issue(4'd0, mk(6,3), 2'd2, 0, 0, 0, 0, -1, 0, '0, 4);     // R4 denied store
    issue(4'd5, mk(9,3), 0, 0, 0, 1, 0, 1, 1, mk(7,3), 4);    // R4 victim moves to way 1
    simple(4'd1, mk(6,4), 0, 0, 1);                           // R1 other set
    simple(4'd7, mk(100,3), 0, 1, 11);                        // R11 lock miss
    simple(4'd4, mk(7,3), 1, 0, 7);                           // R7 dealloc
    simple(4'd1, mk(7,3), 0, 0, 7);                           // R7 gone
    simple(4'd5, mk(9,3), 0, 1, 11);                          // R11 probe with free way
    issue(4'd3, mk(11,3), 0, 0, 0, 1, 0, 1, 0, '0, 6);        // R6 refill way 1
    issue(4'd9, mk(11,3), 0, 0, 4'd0, 0, 0, -1, 0, '0, 6);    // R6 unlocked on alloc
    issue(4'd5, mk(9,3), 0, 0, 0, 1, 0, 2, 1, mk(8,3), 8);    // R8 victim way 2
    simple(4'd15, mk(8,3), 0, 1, 11);                         // R11 undefined op
    simple(4'd1, mk(8,3), 1, 0, 11);                          // R11 state intact

    @(negedge clk);
    cmd_valid_i = 1'b0;
    for (int i = 0; i < 20 && sb_q.size() != 0; i++) @(negedge clk);
    @(negedge clk);
    if (sb_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R13 %0d responses missing, expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule